// File: doc/BRIEF.md
# UART Power-Mode Controller

This block sits between the system power manager and a UART's serial engines. It watches a sleep request, an idle request and an idle-stop select. From these it produces one clock-gate enable for the transmit and receive engines, single-cycle abort strobes, and the level that reaches the TX pin. When sleep is requested, any frame still in flight is abandoned rather than finished. The abort strobes reach the engines on the final enabled clock edge, so both engines drop back to their idle state before their clock stops. While the engines are gated, the TX pin is held at the mark level (logic 1). Configuration and data storage sit in the engines and are never reset by this block, so they survive a sleep period unchanged.

While asleep, a falling edge on the raw RX pin can raise a wake interrupt. A flop clocked by the RX pin itself captures the edge, so no gated clock has to be running. The block's free-running clock then synchronizes it. The interrupt fires only when all of the following hold: the wake bit is armed, the UART is enabled and the receive interrupt is enabled. The wake bit clears itself when the interrupt fires. Idle with the stop select at 0 leaves the engines running. Idle with the select at 1 gates them without any abort, so a frame pauses in place.

Top module: `uart_pwr_ctrl`

## Requirements
- R1: After reset, clk_en is 1, tx_abort, rx_abort and wake_irq are 0, wake_armed is 0, and tx_pin equals tx_eng.
- R2: A sleep request sampled on a clock edge while running gives, in the following cycle, clk_en still 1 and tx_abort equal to tx_busy as sampled on that edge. One cycle later clk_en is 0 and tx_abort is 0.
- R3: rx_abort follows the same timing as tx_abort, but takes its value from rx_busy. If the matching busy input is 0, no abort strobe appears.
- R4: From the cycle in which the abort strobes can appear until sleep is left, tx_pin is 1 whatever tx_eng is.
- R5: An idle request with idle_stop at 0 leaves clk_en at 1. With idle_stop at 1, clk_en is 0 from the cycle after the request is sampled. Neither case produces an abort strobe.
- R6: Once the sleep or idle request is sampled low, clk_en is 1 in the next cycle and tx_pin follows tx_eng again.
- R7: A one-cycle pulse on wake_set arms wake_armed. Suppose the block is asleep with wake_armed, mod_en and rx_int_en all 1, and rx_pin falls between two clock edges. Then wake_irq is 1 for exactly one cycle, namely the cycle after the third rising edge following the fall, and wake_armed is 0 afterwards.
- R8: With mod_en at 0, an RX falling edge during sleep raises no wake_irq, and wake_armed keeps its value.
- R9: With rx_int_en at 0, an RX falling edge during sleep raises no wake_irq.
- R10: An RX falling edge while running or while unarmed raises no wake_irq, and an armed wake_armed stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, never gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | System sleep request, level |
| idle_req | input | 1 | System idle request, level |
| idle_stop | input | 1 | 1 stops the engines in idle, 0 lets them run |
| mod_en | input | 1 | UART enable |
| rx_int_en | input | 1 | Receive interrupt enable |
| wake_set | input | 1 | One-cycle pulse that arms the wake bit |
| rx_pin | input | 1 | Raw serial receive line |
| tx_busy | input | 1 | Transmit engine has a frame in flight |
| rx_busy | input | 1 | Receive engine has a frame in flight |
| tx_eng | input | 1 | Serial level produced by the transmit engine |
| clk_en | output | 1 | Clock-gate enable for both serial engines |
| tx_abort | output | 1 | One-cycle abort strobe to the transmit engine |
| rx_abort | output | 1 | One-cycle abort strobe to the receive engine |
| tx_pin | output | 1 | Level driven onto the TX pin |
| wake_irq | output | 1 | One-cycle wake interrupt |
| wake_armed | output | 1 | Current state of the wake bit |

## Verification
Request changes are applied mid-cycle. Abort strobes are due one rising edge after a sleep request, the gated clock two edges after it, and the re-enabled clock one edge after the request is released. Each of these is sampled at the falling edge that follows exactly that many rising edges. The wake pulse is due after the two-stage synchronizer plus one output register, so it lands three edges after an RX fall. The bench samples wake_irq at each of the six falling edges after the fall, and expects it high at the third only, and only when it should fire at all. The bench sweeps every busy combination for sleep entry and every combination of arm, enable and interrupt enable for wake, resetting between wake cases.

// File: rtl/uart_pwr_pkg.sv
package uart_pwr_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_DRAIN = 2'd1,
    PS_SLEEP = 2'd2,
    PS_IDLE  = 2'd3
  } pwr_state_t;
endpackage

// File: rtl/uart_pwr_fsm.sv
module uart_pwr_fsm
  import uart_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       idle_req,
  input  logic       idle_stop,
  input  logic       tx_busy,
  input  logic       rx_busy,
  output pwr_state_t state,
  output logic       tx_abort,
  output logic       rx_abort
);
  pwr_state_t nxt;
  logic idle_gate;

  assign idle_gate = idle_req && idle_stop;

  always_comb begin
    nxt = state;
    unique case (state)
      PS_RUN:   if (sleep_req) nxt = PS_DRAIN;
                else if (idle_gate) nxt = PS_IDLE;
      PS_DRAIN: nxt = PS_SLEEP;
      PS_SLEEP: if (!sleep_req) nxt = idle_gate ? PS_IDLE : PS_RUN;
      PS_IDLE:  if (sleep_req) nxt = PS_SLEEP;
                else if (!idle_gate) nxt = PS_RUN;
      default:  nxt = PS_RUN;
    endcase
  end

  // Strobes are registered so they are high during the drain cycle and
  // seen by the engines on the last edge before the gate closes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PS_RUN;
      tx_abort <= 1'b0;
      rx_abort <= 1'b0;
    end else begin
      state    <= nxt;
      tx_abort <= (state == PS_RUN) && sleep_req && tx_busy;
      rx_abort <= (state == PS_RUN) && sleep_req && rx_busy;
    end
  end

  AST_TX_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> !tx_abort); // R2
  AST_ABORT_THEN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_abort || rx_abort) |=> (state == PS_SLEEP)); // R3
  AST_NO_ABORT_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_IDLE) |-> (!tx_abort && !rx_abort)); // R5
endmodule

// File: rtl/uart_wake_det.sv
module uart_wake_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  input  logic asleep,
  input  logic mod_en,
  input  logic rx_int_en,
  input  logic wake_set,
  output logic wake_irq,
  output logic wake_armed
);
  localparam int MSB = SYNC_STAGES - 1;

  logic edge_tog;
  logic det_en;
  logic seen_q;
  logic pending;
  logic [SYNC_STAGES-1:0] sync_q;

  assign det_en = asleep && wake_armed && mod_en;

  // Captures an RX fall with no clock running: the pin is the clock.
  always_ff @(negedge rx_pin or negedge rst_n) begin
    if (!rst_n) edge_tog <= 1'b0;
    else if (det_en) edge_tog <= ~edge_tog;
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else sync_q[0] <= edge_tog;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[s] <= 1'b0;
          else sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  assign pending = sync_q[MSB] ^ seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q     <= 1'b0;
      wake_irq   <= 1'b0;
      wake_armed <= 1'b0;
    end else begin
      wake_irq <= 1'b0;
      if (wake_set) wake_armed <= 1'b1;
      if (pending) begin
        seen_q <= sync_q[MSB];
        if (mod_en && rx_int_en) begin
          wake_irq   <= 1'b1;
          wake_armed <= 1'b0;
        end
      end
    end
  end

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq); // R7
  AST_IRQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> $past(wake_armed)); // R7
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> $past(mod_en && rx_int_en)); // R8
endmodule

// File: rtl/uart_pwr_ctrl.sv
module uart_pwr_ctrl
  import uart_pwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic idle_req,
  input  logic idle_stop,
  input  logic mod_en,
  input  logic rx_int_en,
  input  logic wake_set,
  input  logic rx_pin,
  input  logic tx_busy,
  input  logic rx_busy,
  input  logic tx_eng,
  output logic clk_en,
  output logic tx_abort,
  output logic rx_abort,
  output logic tx_pin,
  output logic wake_irq,
  output logic wake_armed
);
  pwr_state_t state;

  uart_pwr_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .idle_req(idle_req),
    .idle_stop(idle_stop), .tx_busy(tx_busy), .rx_busy(rx_busy),
    .state(state), .tx_abort(tx_abort), .rx_abort(rx_abort)
  );

  uart_wake_det #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .asleep(state == PS_SLEEP),
    .mod_en(mod_en), .rx_int_en(rx_int_en), .wake_set(wake_set),
    .wake_irq(wake_irq), .wake_armed(wake_armed)
  );

  assign clk_en = (state == PS_RUN) || (state == PS_DRAIN);
  assign tx_pin = ((state == PS_DRAIN) || (state == PS_SLEEP)) ? 1'b1 : tx_eng;

  AST_MARK_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> tx_pin); // R4
  AST_CLK_DURING_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_abort || rx_abort) |-> clk_en); // R2
  AST_GATE_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort |=> !clk_en); // R3
endmodule

// File: tb/sim_uart_pwr_ctrl.sv
module sim_uart_pwr_ctrl;
  localparam int SYNC = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req = 0, idle_req = 0, idle_stop = 0, mod_en = 0, rx_int_en = 0;
  logic wake_set = 0, rx_pin = 1, tx_busy = 0, rx_busy = 0, tx_eng = 0;
  logic clk_en, tx_abort, rx_abort, tx_pin, wake_irq, wake_armed;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_pwr_ctrl #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .idle_req(idle_req),
    .idle_stop(idle_stop), .mod_en(mod_en), .rx_int_en(rx_int_en),
    .wake_set(wake_set), .rx_pin(rx_pin), .tx_busy(tx_busy), .rx_busy(rx_busy),
    .tx_eng(tx_eng), .clk_en(clk_en), .tx_abort(tx_abort), .rx_abort(rx_abort),
    .tx_pin(tx_pin), .wake_irq(wake_irq), .wake_armed(wake_armed)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; sleep_req = 0; idle_req = 0; idle_stop = 0; wake_set = 0;
    rx_pin = 1; tx_busy = 0; rx_busy = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 clk_en", clk_en, 1'b1);
    chk("R1 tx_abort", tx_abort, 1'b0);
    chk("R1 rx_abort", rx_abort, 1'b0);
    chk("R1 wake_irq", wake_irq, 1'b0);
    chk("R1 wake_armed", wake_armed, 1'b0);
    tx_eng = 1; #1 chk("R1 tx_pin high", tx_pin, 1'b1);
    tx_eng = 0; #1 chk("R1 tx_pin low", tx_pin, 1'b0);

    // Sleep entry over every busy combination
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      tx_busy = i[0]; rx_busy = i[1]; tx_eng = 0; sleep_req = 1;
      @(negedge clk);
      chk("R2 clk_en in drain", clk_en, 1'b1);
      chk("R2 tx_abort", tx_abort, i[0]);
      chk("R3 rx_abort", rx_abort, i[1]);
      chk("R4 tx_pin drain", tx_pin, 1'b1);
      tx_busy = 0; rx_busy = 0;
      @(negedge clk);
      chk("R2 clk_en gated", clk_en, 1'b0);
      chk("R2 tx_abort ends", tx_abort, 1'b0);
      chk("R3 rx_abort ends", rx_abort, 1'b0);
      chk("R4 tx_pin sleep", tx_pin, 1'b1);
      tx_eng = 1; #1 tx_eng = 0; #1 chk("R4 tx_pin ignores engine", tx_pin, 1'b1);
      sleep_req = 0;
      @(negedge clk);
      chk("R6 clk_en back", clk_en, 1'b1);
      chk("R6 tx_pin follows", tx_pin, 1'b0);
    end

    // Idle, both stop selections
    for (int s = 0; s < 2; s++) begin
      @(negedge clk);
      idle_stop = s[0]; idle_req = 1; tx_busy = 1; rx_busy = 1;
      @(negedge clk);
      chk("R5 idle clk_en", clk_en, !s[0]);
      chk("R5 idle tx_abort", tx_abort, 1'b0);
      chk("R5 idle rx_abort", rx_abort, 1'b0);
      @(negedge clk);
      chk("R5 idle clk_en held", clk_en, !s[0]);
      idle_req = 0; tx_busy = 0; rx_busy = 0;
      @(negedge clk);
      chk("R6 clk_en after idle", clk_en, 1'b1);
    end

    // Wake over arm x mod_en x rx_int_en
    for (int i = 0; i < 8; i++) begin
      automatic logic arm = i[0], men = i[1], rie = i[2];
      automatic logic fire = arm && men && rie;
      do_reset();
      mod_en = men; rx_int_en = rie;
      if (arm) begin wake_set = 1; @(negedge clk); wake_set = 0; end
      @(negedge clk);
      chk("R7 wake_armed set", wake_armed, arm);
      sleep_req = 1;
      repeat (2) @(negedge clk);
      rx_pin = 0;
      for (int n = 1; n <= 6; n++) begin
        @(negedge clk);
        if (fire) chk("R7 wake_irq timing", wake_irq, n == SYNC + 1);
        else if (!men) chk("R8 no irq when disabled", wake_irq, 1'b0);
        else if (!rie) chk("R9 no irq without rx int", wake_irq, 1'b0);
        else chk("R10 no irq when unarmed", wake_irq, 1'b0);
      end
      if (!men) chk("R8 wake_armed kept", wake_armed, arm);
      else chk("R7 wake_armed after", wake_armed, arm && !fire);
      rx_pin = 1; sleep_req = 0;
      repeat (2) @(negedge clk);
    end

    // R10 falling edge while running
    do_reset();
    mod_en = 1; rx_int_en = 1; wake_set = 1;
    @(negedge clk); wake_set = 0;
    @(negedge clk);
    rx_pin = 0;
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      chk("R10 no irq while running", wake_irq, 1'b0);
    end
    chk("R10 armed stays", wake_armed, 1'b1);
    rx_pin = 1;

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule